// File: doc/BRIEF.md
# Direct-Mapped Translation Cache with Access Protection

This block caches page table entries so that a virtual address can be turned into a physical address without a trip to the page table. The virtual address splits into a page offset (low `OFF_W` bits) and a virtual page number. The low `IDX_W` bits of the page number pick one of `2**IDX_W` slots. The remaining upper bits are kept in that slot as a tag. Each slot stores a physical page number of `PA_W-OFF_W` bits and five management flags: valid, dirty, read, write and execute.

A lookup presents an address and an access kind. One clock later the block returns one of three results: a hit with the physical address (cached page number followed by the untouched offset), a miss, or a hit that breaks the slot's permissions and so raises a protection fault. A write that is allowed marks the slot dirty. After a miss the walker writes the slot through the fill port. The flush input drops every cached translation at once.

Top module: `tlb_dm`

## Requirements
- R1: After reset every slot is invalid, all response outputs are low, and the first lookup of any address misses.
- R2: The response appears in the cycle after the request, with `rsp_valid` high for exactly that cycle. A hit needs a valid slot whose stored tag equals the address tag. A tag mismatch at the same index misses.
- R3: On a hit, `rsp_paddr` is the slot's physical page number above the request's page offset. On a miss or when idle, `rsp_paddr` is zero.
- R4: The access kind codes are 00 read (needs R), 01 write (needs W), 10 instruction fetch (needs X) and 11 reserved (never allowed). A hit whose needed permission is clear raises `rsp_fault`.
- R5: `rsp_fault` is only ever raised together with `rsp_hit`. On a miss `rsp_miss` is high and `rsp_fault` and `rsp_dirty` are low.
- R6: `rsp_dirty` reports the slot's dirty flag as it was before the lookup. A write that hits a slot with W set sets its dirty flag for all later lookups. A faulting write leaves the flag unchanged.
- R7: A flush invalidates every slot in one cycle, so a lookup in the next cycle misses.
- R8: A fill stores the tag, page number and flags at the index of `fill_vaddr`. It replaces whatever was in that slot. A lookup in the next cycle sees the new contents.
- R9: A lookup issued in the same cycle as a fill or flush sees the slot contents from before that cycle.
- R10: When a flush and a fill come in the same cycle, the filled slot ends valid and all other slots end invalid.
- R11: When a fill and a dirty-setting write hit target the same slot in the same cycle, the fill's dirty flag is what gets stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 reserved |
| fill_en | input | 1 | Write a slot |
| fill_vaddr | input | VA_W | Virtual address whose slot and tag are written |
| fill_ppn | input | PA_W-OFF_W | Physical page number to store |
| fill_dirty | input | 1 | Dirty flag to store |
| fill_rd | input | 1 | Read permission to store |
| fill_wr | input | 1 | Write permission to store |
| fill_ex | input | 1 | Execute permission to store |
| flush | input | 1 | Invalidate all slots |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No translation |
| rsp_fault | output | 1 | Permission violated on a hit |
| rsp_dirty | output | 1 | Slot dirty flag before the lookup |
| rsp_paddr | output | PA_W | Translated physical address |

## Verification
The collisions that matter are a lookup landing in the same cycle as a slot update. The update can be a fill or flush on that slot, or a fill racing a dirty-setting write. The bench drives a lookup together with a fill to the lookup's own slot and expects the old translation in the response and the new one on the next lookup. It also drives a write hit alongside a clean fill of the same slot and expects a later read to report the slot clean. The expected results come from a bench-side slot model that applies the update order fixed by the requirements.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  typedef struct packed {
    logic d;
    logic r;
    logic w;
    logic x;
  } perm_t;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 4,
  parameter int PPN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PPN_W-1:0] rd_ppn,
  output perm_t            rd_perm,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PPN_W-1:0] fill_ppn,
  input  perm_t            fill_perm,
  input  logic             dirty_set,
  input  logic [IDX_W-1:0] dirty_idx
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int ENT_W   = TAG_W + PPN_W + $bits(perm_t);

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0]            valid_d;
  logic [ENTRIES-1:0][ENT_W-1:0] ent_flat;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [ENT_W-1:0] ent_q;
    logic [ENT_W-1:0] ent_d;
    logic             ent_en;
    logic             sel_fill;
    logic             sel_dirty;

    assign sel_fill  = fill_en && (fill_idx == IDX_W'(e));
    assign sel_dirty = dirty_set && (dirty_idx == IDX_W'(e));

    always_comb begin
      valid_d[e] = valid_q[e];
      if (flush)    valid_d[e] = 1'b0;
      if (sel_fill) valid_d[e] = 1'b1;
    end

    always_comb begin
      ent_en = sel_fill || sel_dirty;
      ent_d  = ent_q;
      if (sel_fill) begin
        ent_d = {fill_tag, fill_ppn, fill_perm};
      end else if (sel_dirty) begin
        ent_d[3] = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (ent_en) ent_q <= ent_d;
    end

    assign ent_flat[e] = ent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  assign rd_valid = valid_q[rd_idx];
  assign {rd_tag, rd_ppn, rd_perm} = ent_flat[rd_idx];
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int PPN_W = 6,
  parameter int OFF_W = 8
) (
  input  logic                   ent_valid,
  input  logic [TAG_W-1:0]       ent_tag,
  input  logic [PPN_W-1:0]       ent_ppn,
  input  perm_t                  ent_perm,
  input  logic [TAG_W-1:0]       req_tag,
  input  logic [OFF_W-1:0]       req_off,
  input  acc_e                   req_acc,
  output logic                   hit,
  output logic                   fault,
  output logic                   mark_dirty,
  output logic                   dirty,
  output logic [PPN_W+OFF_W-1:0] paddr
);
  logic allowed;

  always_comb begin
    unique case (req_acc)
      ACC_RD:  allowed = ent_perm.r;
      ACC_WR:  allowed = ent_perm.w;
      ACC_EX:  allowed = ent_perm.x;
      default: allowed = 1'b0;
    endcase
  end

  assign hit        = ent_valid && (ent_tag == req_tag);
  assign fault      = hit && !allowed;
  assign mark_dirty = hit && (req_acc == ACC_WR) && ent_perm.w;
  assign dirty      = hit && ent_perm.d;
  assign paddr      = hit ? {ent_ppn, req_off} : '0;
endmodule

// File: rtl/tlb_dm.sv
module tlb_dm
  import tlb_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int PA_W  = 14,
  parameter int OFF_W = 8,
  parameter int IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic [1:0]            lk_acc,
  input  logic                  fill_en,
  input  logic [VA_W-1:0]       fill_vaddr,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic                  fill_dirty,
  input  logic                  fill_rd,
  input  logic                  fill_wr,
  input  logic                  fill_ex,
  input  logic                  flush,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic                  rsp_miss,
  output logic                  rsp_fault,
  output logic                  rsp_dirty,
  output logic [PA_W-1:0]       rsp_paddr
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [OFF_W-1:0] lk_off;
  logic             ent_valid;
  logic [TAG_W-1:0] ent_tag;
  logic [PPN_W-1:0] ent_ppn;
  perm_t            ent_perm;
  perm_t            fill_perm;
  logic             lu_hit;
  logic             lu_fault;
  logic             lu_mark;
  logic             lu_dirty;
  logic [PA_W-1:0]  lu_paddr;

  logic             valid_d, hit_d, miss_d, fault_d, dirty_d;
  logic [PA_W-1:0]  paddr_d;

  assign {lk_tag, lk_idx, lk_off} = lk_vaddr;
  assign fill_perm = '{d: fill_dirty, r: fill_rd, w: fill_wr, x: fill_ex};

  tlb_entry_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (lk_idx),
    .rd_valid  (ent_valid),
    .rd_tag    (ent_tag),
    .rd_ppn    (ent_ppn),
    .rd_perm   (ent_perm),
    .flush     (flush),
    .fill_en   (fill_en),
    .fill_idx  (fill_vaddr[OFF_W +: IDX_W]),
    .fill_tag  (fill_vaddr[VA_W-1 -: TAG_W]),
    .fill_ppn  (fill_ppn),
    .fill_perm (fill_perm),
    .dirty_set (lk_valid && lu_mark),
    .dirty_idx (lk_idx)
  );

  tlb_lookup #(.TAG_W(TAG_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_lookup (
    .ent_valid  (ent_valid),
    .ent_tag    (ent_tag),
    .ent_ppn    (ent_ppn),
    .ent_perm   (ent_perm),
    .req_tag    (lk_tag),
    .req_off    (lk_off),
    .req_acc    (acc_e'(lk_acc)),
    .hit        (lu_hit),
    .fault      (lu_fault),
    .mark_dirty (lu_mark),
    .dirty      (lu_dirty),
    .paddr      (lu_paddr)
  );

  always_comb begin
    valid_d = lk_valid;
    hit_d   = lk_valid && lu_hit;
    miss_d  = lk_valid && !lu_hit;
    fault_d = lk_valid && lu_fault;
    dirty_d = lk_valid && lu_dirty;
    paddr_d = lk_valid ? lu_paddr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_hit   <= hit_d;
      rsp_miss  <= miss_d;
      rsp_fault <= fault_d;
      rsp_dirty <= dirty_d;
      rsp_paddr <= paddr_d;
    end
  end
endmodule

// File: rtl/tlb_dm_chk.sv
module tlb_dm_chk #(
  parameter int VA_W  = 16,
  parameter int PA_W  = 14,
  parameter int OFF_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lk_valid,
  input logic [VA_W-1:0]       lk_vaddr,
  input logic                  fill_en,
  input logic [VA_W-1:0]       fill_vaddr,
  input logic [PA_W-OFF_W-1:0] fill_ppn,
  input logic                  flush,
  input logic                  rsp_valid,
  input logic                  rsp_hit,
  input logic                  rsp_miss,
  input logic                  rsp_fault,
  input logic [PA_W-1:0]       rsp_paddr
);
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r2_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid && !rsp_hit && !rsp_miss);
  a_r5_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit);
  a_r5_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss));
  a_r3_miss_paddr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_paddr == '0);
  a_r7_flush_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) && !$past(fill_en) && lk_valid |=> rsp_miss);
  a_r8_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fill_en) && lk_valid &&
    (lk_vaddr[VA_W-1:OFF_W] == $past(fill_vaddr[VA_W-1:OFF_W]))
    |=> rsp_hit && (rsp_paddr[PA_W-1:OFF_W] == $past(fill_ppn, 2))
        && (rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));
endmodule

bind tlb_dm tlb_dm_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_vaddr   (lk_vaddr),
  .fill_en    (fill_en),
  .fill_vaddr (fill_vaddr),
  .fill_ppn   (fill_ppn),
  .flush      (flush),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_miss   (rsp_miss),
  .rsp_fault  (rsp_fault),
  .rsp_paddr  (rsp_paddr)
);

// File: tb/tlb_dm_tb.sv
`timescale 1ns/1ps
module tlb_dm_tb;
  localparam int VA_W = 16, PA_W = 14, OFF_W = 8, IDX_W = 4;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int NSLOT = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_valid;
  logic [VA_W-1:0] lk_vaddr;
  logic [1:0] lk_acc;
  logic fill_en;
  logic [VA_W-1:0] fill_vaddr;
  logic [PPN_W-1:0] fill_ppn;
  logic fill_dirty, fill_rd, fill_wr, fill_ex, flush;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
  logic [PA_W-1:0] rsp_paddr;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit        m_v [NSLOT];
  bit [3:0]  m_tag [NSLOT];
  bit [5:0]  m_ppn [NSLOT];
  bit        m_d [NSLOT], m_r [NSLOT], m_w [NSLOT], m_x [NSLOT];

  always #4 clk = ~clk;

  tlb_dm #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_acc(lk_acc), .fill_en(fill_en), .fill_vaddr(fill_vaddr),
    .fill_ppn(fill_ppn), .fill_dirty(fill_dirty), .fill_rd(fill_rd),
    .fill_wr(fill_wr), .fill_ex(fill_ex), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_dirty(rsp_dirty), .rsp_paddr(rsp_paddr)
  );

  task automatic idle_inputs();
    lk_valid = 0; lk_vaddr = '0; lk_acc = '0; fill_en = 0; fill_vaddr = '0;
    fill_ppn = '0; fill_dirty = 0; fill_rd = 0; fill_wr = 0; fill_ex = 0; flush = 0;
  endtask

  task automatic check_out(string req, bit ev, bit eh, bit em, bit ef, bit ed,
                           logic [PA_W-1:0] ep);
    n_vec++;
    if ({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty} !== {ev, eh, em, ef, ed}
        || rsp_paddr !== ep) begin
      n_bad++;
      $display("FAIL %s: got v/h/m/f/d=%b%b%b%b%b pa=%h, want %b%b%b%b%b pa=%h",
               req, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_paddr,
               ev, eh, em, ef, ed, ep);
    end
  endtask

  // Called at a falling edge; checks the response one cycle later.
  task automatic op(bit lk, logic [15:0] va, logic [1:0] acc, bit fe,
                    logic [15:0] fva, logic [5:0] fppn, logic [3:0] fdrwx,
                    bit fl, string req);
    int  idx = int'(va[11:8]);
    int  fidx = int'(fva[11:8]);
    bit  eh, ef, ed, ok;
    logic [PA_W-1:0] ep;
    string lbl;
    eh = lk && m_v[idx] && (m_tag[idx] == va[15:12]);
    case (acc)
      2'b00: ok = m_r[idx];
      2'b01: ok = m_w[idx];
      2'b10: ok = m_x[idx];
      default: ok = 0;
    endcase
    ef = eh && !ok;
    ed = eh && m_d[idx];
    ep = eh ? {m_ppn[idx], va[7:0]} : '0;
    if (req != "") lbl = req;
    else if (!lk) lbl = "R2";
    else if (!eh) lbl = "R5";
    else if (ef) lbl = "R4";
    else if (acc == 2'b01) lbl = "R6";
    else lbl = "R3";
    if (eh && acc == 2'b01 && m_w[idx]) m_d[idx] = 1;
    if (fl) for (int i = 0; i < NSLOT; i++) m_v[i] = 0;
    if (fe) begin
      m_v[fidx] = 1; m_tag[fidx] = fva[15:12]; m_ppn[fidx] = fppn;
      {m_d[fidx], m_r[fidx], m_w[fidx], m_x[fidx]} = fdrwx;
    end
    lk_valid = lk; lk_vaddr = va; lk_acc = acc;
    fill_en = fe; fill_vaddr = fva; fill_ppn = fppn;
    {fill_dirty, fill_rd, fill_wr, fill_ex} = fdrwx; flush = fl;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    check_out(lbl, lk, eh, lk && !eh, ef, ed, ep);
  endtask

  task automatic fill_slot(int s, logic [3:0] tg, logic [5:0] pp, logic [3:0] fl4);
    op(0, '0, 2'b00, 1, {tg, 4'(s), 8'h00}, pp, fl4, 0, "R8");
  endtask

  function automatic logic [15:0] va_of(int s, logic [3:0] tg, logic [7:0] off);
    return {tg, 4'(s), off};
  endfunction

  initial begin
    for (int i = 0; i < NSLOT; i++) begin
      m_v[i] = 0; m_tag[i] = 0; m_ppn[i] = 0; m_d[i] = 0; m_r[i] = 0; m_w[i] = 0; m_x[i] = 0;
    end
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out("R1", 0, 0, 0, 0, 0, '0);
    rst_n = 1;
    @(negedge clk);
    check_out("R1", 0, 0, 0, 0, 0, '0);
    for (int s = 0; s < NSLOT; s++) op(1, va_of(s, 4'(s), 8'h11), 2'b00, 0, '0, '0, '0, 0, "R1");
    op(0, '0, 2'b00, 0, '0, '0, '0, 0, "R2");

    // Fill every slot: perms follow the slot number (r=bit0, w=bit1, x=bit2), clean.
    for (int s = 0; s < NSLOT; s++)
      fill_slot(s, 4'(s) ^ 4'h5, 6'(s * 3 + 1), {1'b0, 1'(s), 1'(s >> 1), 1'(s >> 2)});

    // Sweep every slot, access kind and tag match/mismatch, twice to observe dirty.
    for (int pass = 0; pass < 2; pass++)
      for (int s = 0; s < NSLOT; s++)
        for (int a = 0; a < 4; a++)
          for (int mm = 0; mm < 2; mm++)
            op(1, va_of(s, (4'(s) ^ 4'h5) + 4'(mm), 8'(s * 17 + a * 5 + pass)),
               2'(a), 0, '0, '0, '0, 0, "");

    // R9: lookup and refill of the same slot in one cycle.
    op(1, va_of(3, 4'h6, 8'hA5), 2'b00, 1, va_of(3, 4'hC, 8'h00), 6'h2A, 4'b0111, 0, "R9");
    op(1, va_of(3, 4'hC, 8'h5A), 2'b10, 0, '0, '0, '0, 0, "R9");
    op(1, va_of(3, 4'h6, 8'h5A), 2'b00, 0, '0, '0, '0, 0, "R9");

    // R11: write hit that would mark dirty, racing a clean fill of that slot.
    op(1, va_of(3, 4'hC, 8'h01), 2'b01, 1, va_of(3, 4'hC, 8'h00), 6'h15, 4'b0110, 0, "R11");
    op(1, va_of(3, 4'hC, 8'h02), 2'b00, 0, '0, '0, '0, 0, "R11");
    op(1, va_of(3, 4'hC, 8'h03), 2'b01, 0, '0, '0, '0, 0, "R6");
    op(1, va_of(3, 4'hC, 8'h04), 2'b00, 0, '0, '0, '0, 0, "R6");

    // R7: flush, lookup in the same cycle still sees old contents (R9), then all miss.
    op(1, va_of(3, 4'hC, 8'h07), 2'b00, 0, '0, '0, '0, 1, "R9");
    for (int s = 0; s < NSLOT; s++) op(1, va_of(s, 4'(s) ^ 4'h5, 8'h33), 2'b00, 0, '0, '0, '0, 0, "R7");
    op(1, va_of(3, 4'hC, 8'h07), 2'b00, 0, '0, '0, '0, 0, "R7");

    // R10: flush and fill together.
    fill_slot(9, 4'h1, 6'h09, 4'b0100);
    op(0, '0, 2'b00, 1, va_of(7, 4'hE, 8'h00), 6'h3F, 4'b1111, 1, "R10");
    op(1, va_of(7, 4'hE, 8'hFF), 2'b10, 0, '0, '0, '0, 0, "R10");
    op(1, va_of(9, 4'h1, 8'h00), 2'b00, 0, '0, '0, '0, 0, "R10");

    // R8: replacement of a valid slot.
    fill_slot(7, 4'h2, 6'h05, 4'b0001);
    op(1, va_of(7, 4'hE, 8'h10), 2'b10, 0, '0, '0, '0, 0, "R8");
    op(1, va_of(7, 4'h2, 8'h10), 2'b10, 0, '0, '0, '0, 0, "R8");
    op(1, va_of(7, 4'h2, 8'h11), 2'b11, 0, '0, '0, '0, 0, "R4");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule